// File: doc/BRIEF.md
# Redundant Reference Clock Failover Controller

This block decides which of two redundant reference clocks feeds a downstream PLL. It also flags each reference that has stopped toggling. A fast, free-running system clock samples everything. The two references, the PLL feedback clock and an activity copy of the PLL output clock each pass through a two-flop synchroniser. Edge counters then judge whether a signal has gone quiet for a whole period of a second, slower clock. No fixed timeout is used for this.

In automatic mode, the first reference that fails is condemned and the selection locks to the other reference. The lock holds until software pulls the active-low alarm input low; a falling edge on that input produces a one-cycle clear. When the feedback clock goes quiet, both references are condemned at once. With both condemned, the block asks the PLL to drop to its minimum frequency.

In override mode the selection always follows the primary-select pin, and the flags still latch. A lost feedback clock then raises the minimum-frequency request for a timed minimum, and longer if feedback has not returned by then.

Top module: `refclk_failover`

## Requirements
- R1: After the asynchronous active-low reset, both bad flags and the fallback request are 0, and the selection equals primary select.
- R2: A reference that makes no transition across two rising edges of the synchronised feedback clock latches its bad flag to 1. A reference that keeps toggling never sets its flag.
- R3: When feedback makes no transition across two rising edges of the synchronised output clock, both bad flags latch to 1 in the same cycle.
- R4: While both bad flags are 0, the selection output equals primary select in either mode. Primary select 0 gives output 0, meaning reference 0; primary select 1 gives output 1, meaning reference 1.
- R5: With override 0, the first flag to set moves the selection to the other reference. The flags and the selection then stay fixed when primary select changes or when the failed input recovers.
- R6: Only a falling edge of the alarm input clears. It yields a clear one cycle wide, three system clocks after the input is sampled low. The clear drops both flags and returns the selection to primary select. A rising edge clears nothing. The clear overrides a detection that falls in the same cycle.
- R7: With override 0 and both flags set, the fallback request is 1 and stays 1 until a clear. If both references are still stuck after the clear, both flags set again only after a further feedback window.
- R8: With override 1, the selection equals primary select even with flags set, and the flags still latch as in R2 and R3.
- R9: With override 1, a feedback loss raises the fallback request for exactly HOLD_CYC cycles if feedback resumes within that time. Otherwise it stays high until the feedback activity monitor sees transitions again.
- R10: When both flags become set in the same cycle with override 0, the selection locks to reference 0 (output 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock, faster than all monitored clocks |
| rst_n | input | 1 | Asynchronous active-low module reset |
| ref0_i | input | 1 | Reference clock 0 |
| ref1_i | input | 1 | Reference clock 1 |
| fb_i | input | 1 | PLL feedback clock |
| outclk_i | input | 1 | Activity copy of the PLL output clock, used as the window for feedback |
| pri_sel_i | input | 1 | Primary select: 0 for reference 0, 1 for reference 1 |
| manual_i | input | 1 | Override: 1 disables automatic failover |
| alarm_n_i | input | 1 | Alarm clear, acts on its falling edge |
| sel_o | output | 1 | Selected reference: 0 for reference 0, 1 for reference 1 |
| bad0_o | output | 1 | Latched bad flag of reference 0 |
| bad1_o | output | 1 | Latched bad flag of reference 1 |
| fallback_o | output | 1 | Request for the PLL to run at minimum frequency |

## Verification
The alarm clear and a stuck-input detection can land in the same system cycle. A window counter reaching its limit then competes with the clear that resets it. The bench provokes this by holding both references stuck and issuing clears. It expects both flags and the fallback request to read 0 five cycles after the alarm drops, and both flags to return only after another feedback window, with the selection locked to reference 0. Changes to primary select that meet an automatic lock in the same cycle are also mixed in. They are judged against a bench model of the lock state.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
    typedef enum logic [1:0] {
        S_FOLLOW = 2'd0,
        S_LOCK0  = 2'd1,
        S_LOCK1  = 2'd2
    } sel_state_t;

    typedef enum logic [1:0] {
        F_IDLE  = 2'd0,
        F_HOLD  = 2'd1,
        F_DRAIN = 2'd2
    } fb_state_t;

    localparam int MON_N   = 4;
    localparam int IDX_FB  = 2;
    localparam int IDX_OUT = 3;
endpackage

// File: rtl/rcf_sync.sv
module rcf_sync #(
    parameter int         W       = 1,
    parameter logic [0:0] RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= {W{RST_VAL}};
            q    <= {W{RST_VAL}};
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rcf_activity.sv
module rcf_activity #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic mon,
    input  logic win,
    output logic dead
);
    localparam int            CW  = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic          mon_q, win_q;
    logic [CW-1:0] cnt;
    logic          mon_edge, win_rise;

    assign mon_edge = mon ^ mon_q;
    assign win_rise = win & ~win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= 1'b0;
            win_q <= 1'b0;
            cnt   <= '0;
        end else begin
            mon_q <= mon;
            win_q <= win;
            if (clear || mon_edge)
                cnt <= '0;
            else if (win_rise && (cnt < LIM))
                cnt <= cnt + 1'b1;
        end
    end

    assign dead = (cnt == LIM);

    p_dead_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dead && !clear && !mon_edge) |=> dead);

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM);
endmodule

// File: rtl/rcf_ctrl.sv
module rcf_ctrl
    import rcf_pkg::*;
#(
    parameter int HOLD_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic ref0_dead,
    input  logic ref1_dead,
    input  logic fb_dead,
    input  logic pri_sel,
    input  logic manual,
    output logic sel,
    output logic bad0,
    output logic bad1,
    output logic fallback
);
    localparam int            TW        = $clog2(HOLD_CYC + 1);
    localparam logic [TW-1:0] HOLD_LOAD = TW'(HOLD_CYC - 1);

    sel_state_t    st, st_n;
    fb_state_t     fst, fst_n;
    logic          b0_q, b1_q, b0_n, b1_n;
    logic [TW-1:0] tmr, tmr_n;

    // Flag latches: set by any detection, cleared only by the alarm pulse.
    always_comb begin
        if (clear) begin
            b0_n = 1'b0;
            b1_n = 1'b0;
        end else begin
            b0_n = b0_q | ref0_dead | fb_dead;
            b1_n = b1_q | ref1_dead | fb_dead;
        end
    end

    // Selection state machine.
    always_comb begin
        st_n = st;
        if (clear || manual) begin
            st_n = S_FOLLOW;
        end else begin
            unique case (st)
                S_FOLLOW: begin
                    if (b0_n && !b1_n)
                        st_n = S_LOCK1;
                    else if (b1_n)
                        st_n = S_LOCK0;
                end
                S_LOCK0, S_LOCK1: st_n = st;
                default:          st_n = S_FOLLOW;
            endcase
        end
    end

    // Override-mode feedback fallback state machine.
    always_comb begin
        fst_n = fst;
        tmr_n = tmr;
        unique case (fst)
            F_IDLE: begin
                if (manual && fb_dead) begin
                    fst_n = F_HOLD;
                    tmr_n = HOLD_LOAD;
                end
            end
            F_HOLD: begin
                if (tmr == '0)
                    fst_n = fb_dead ? F_DRAIN : F_IDLE;
                else
                    tmr_n = tmr - 1'b1;
            end
            F_DRAIN: begin
                if (!fb_dead)
                    fst_n = F_IDLE;
            end
            default: fst_n = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= S_FOLLOW;
            fst  <= F_IDLE;
            tmr  <= '0;
            b0_q <= 1'b0;
            b1_q <= 1'b0;
        end else begin
            st   <= st_n;
            fst  <= fst_n;
            tmr  <= tmr_n;
            b0_q <= b0_n;
            b1_q <= b1_n;
        end
    end

    always_comb begin
        bad0     = b0_q;
        bad1     = b1_q;
        sel      = (manual || st == S_FOLLOW) ? pri_sel : (st == S_LOCK1);
        fallback = (!manual && b0_q && b1_q) || (fst != F_IDLE);
    end

    p_clear_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!bad0 && !bad1 && sel == pri_sel));

    p_flag0_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bad0 && !clear) |=> bad0);

    p_flag1_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bad1 && !clear) |=> bad1);

    p_dual_on_fb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_dead && !clear) |=> (bad0 && bad1));

    p_lock_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_FOLLOW && !manual && !clear) |=> (st == $past(st)));

    p_auto_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual && bad0 && bad1 && !clear) |=> (fallback || manual));

    p_hold_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fst == F_HOLD && tmr != '0) |=> fallback);

    p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bad0 && !bad1) |-> (sel == pri_sel));
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover
    import rcf_pkg::*;
#(
    parameter int REF_LIMIT = 2,
    parameter int FB_LIMIT  = 2,
    parameter int HOLD_CYC  = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref0_i,
    input  logic ref1_i,
    input  logic fb_i,
    input  logic outclk_i,
    input  logic pri_sel_i,
    input  logic manual_i,
    input  logic alarm_n_i,
    output logic sel_o,
    output logic bad0_o,
    output logic bad1_o,
    output logic fallback_o
);
    logic [MON_N-1:0] mon_s;
    logic             alarm_s, alarm_q, clr;
    logic [1:0]       ref_dead;
    logic             fb_dead;

    rcf_sync #(.W(MON_N), .RST_VAL(1'b0)) u_sync_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({outclk_i, fb_i, ref1_i, ref0_i}),
        .q     (mon_s)
    );

    rcf_sync #(.W(1), .RST_VAL(1'b1)) u_sync_alarm (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (alarm_n_i),
        .q     (alarm_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alarm_q <= 1'b1;
        else        alarm_q <= alarm_s;
    end

    assign clr = alarm_q & ~alarm_s;

    for (genvar g = 0; g < 2; g++) begin : g_ref
        rcf_activity #(.LIMIT(REF_LIMIT)) u_mon (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (clr),
            .mon   (mon_s[g]),
            .win   (mon_s[IDX_FB]),
            .dead  (ref_dead[g])
        );
    end

    rcf_activity #(.LIMIT(FB_LIMIT)) u_fb_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clr),
        .mon   (mon_s[IDX_FB]),
        .win   (mon_s[IDX_OUT]),
        .dead  (fb_dead)
    );

    rcf_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clr),
        .ref0_dead (ref_dead[0]),
        .ref1_dead (ref_dead[1]),
        .fb_dead   (fb_dead),
        .pri_sel   (pri_sel_i),
        .manual    (manual_i),
        .sel       (sel_o),
        .bad0      (bad0_o),
        .bad1      (bad1_o),
        .fallback  (fallback_o)
    );

    p_clear_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !clr);
endmodule

// File: tb/refclk_failover_tb.sv
module refclk_failover_tb;
    localparam int HOLD = 40;

    logic clk, rst_n, ref0, ref1, fb, outclk, pri, man, alarm_n;
    logic sel, bad0, bad1, fallback;
    int   errors = 0;
    int   checks = 0;
    bit   done   = 0;
    bit   run [4];
    int   half [4];
    int   lock = 0;

    refclk_failover #(.REF_LIMIT(2), .FB_LIMIT(2), .HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref0_i(ref0), .ref1_i(ref1), .fb_i(fb),
        .outclk_i(outclk), .pri_sel_i(pri), .manual_i(man), .alarm_n_i(alarm_n),
        .sel_o(sel), .bad0_o(bad0), .bad1_o(bad1), .fallback_o(fallback)
    );

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    // Monitored clock generators, driven on the falling system edge.
    initial begin
        int cnt [4];
        for (int i = 0; i < 4; i++) cnt[i] = 0;
        ref0 = 0; ref1 = 0; fb = 0; outclk = 0;
        forever begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                if (run[i]) begin
                    cnt[i]++;
                    if (cnt[i] >= half[i]) begin
                        cnt[i] = 0;
                        case (i)
                            0: ref0 = ~ref0;
                            1: ref1 = ~ref1;
                            2: fb = ~fb;
                            default: outclk = ~outclk;
                        endcase
                    end
                end
            end
        end
    end

    function automatic logic exp_sel(logic m, logic p, int lk);
        if (m || lk == 0) return p;
        return (lk == 2);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic clear_pulse();
        alarm_n = 1'b0;
        wait_n(5);
        lock = 0;
        chk("R6 flag0 cleared", bad0, 0);
        chk("R6 flag1 cleared", bad1, 0);
        chk("R6 selection returns", sel, exp_sel(man, pri, lock));
        alarm_n = 1'b1;
        wait_n(6);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int cnt;
        void'($urandom(32'd4242));
        half[0] = 3; half[1] = 4; half[2] = 6; half[3] = 8;
        for (int i = 0; i < 4; i++) run[i] = 1'b1;
        rst_n = 1'b0; pri = 1'b1; man = 1'b0; alarm_n = 1'b1;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1 reset sel", sel, 1);
        chk("R1 reset bad0", bad0, 0);
        chk("R1 reset bad1", bad1, 0);
        chk("R1 reset fallback", fallback, 0);
        wait_n(60);
        chk("R2 healthy bad0", bad0, 0);
        chk("R2 healthy bad1", bad1, 0);

        // Random follow phase with all clocks healthy.
        for (int i = 0; i < 150; i++) begin
            pri = 1'($urandom % 2);
            man = 1'($urandom % 2);
            if (i % 17 == 3) alarm_n = 1'b0;
            if (i % 17 == 9) alarm_n = 1'b1;
            wait_n(1 + ($urandom % 3));
            chk(man ? "R8 follow" : "R4 follow", sel, exp_sel(man, pri, 0));
            chk("R2 no false flag", bad0 | bad1, 0);
            chk("R9 no false fallback", fallback, 0);
        end
        alarm_n = 1'b1; man = 1'b0; pri = 1'b0;
        wait_n(8);

        // Reference 0 fails in automatic mode.
        run[0] = 1'b0;
        wait_n(50);
        lock = 2;
        chk("R2 bad0 latched", bad0, 1);
        chk("R2 bad1 clear", bad1, 0);
        chk("R5 failover to ref1", sel, exp_sel(man, pri, lock));
        pri = 1'b1; wait_n(1);
        pri = 1'b0; wait_n(1);
        chk("R5 lock ignores select", sel, exp_sel(man, pri, lock));
        run[0] = 1'b1;
        wait_n(50);
        chk("R5 flag holds on recovery", bad0, 1);
        chk("R7 single flag no fallback", fallback, 0);

        // Clear, then fail reference 1 while alarm stays low.
        alarm_n = 1'b0;
        wait_n(5);
        lock = 0;
        chk("R6 clear bad0", bad0, 0);
        chk("R6 clear sel", sel, exp_sel(man, pri, lock));
        run[1] = 1'b0;
        wait_n(50);
        lock = 1;
        chk("R2 bad1 latched", bad1, 1);
        chk("R5 failover to ref0", sel, exp_sel(man, pri, lock));
        alarm_n = 1'b1;
        wait_n(8);
        chk("R6 rising edge no clear", bad1, 1);
        run[1] = 1'b1;
        clear_pulse();

        // Both references stuck: fallback, clear, re-latch.
        pri = 1'b1;
        run[0] = 1'b0; run[1] = 1'b0;
        wait_n(50);
        chk("R7 both flags", bad0 & bad1, 1);
        chk("R7 fallback", fallback, 1);
        chk("R10 lock ref0", sel, 0);
        alarm_n = 1'b0;
        wait_n(5);
        chk("R6 clear wins flags", bad0 | bad1, 0);
        chk("R7 fallback released", fallback, 0);
        chk("R6 sel to primary", sel, 1);
        wait_n(45);
        chk("R7 re-latch both", bad0 & bad1, 1);
        chk("R10 re-latch ref0", sel, 0);
        alarm_n = 1'b1;
        run[0] = 1'b1; run[1] = 1'b1;
        wait_n(40);
        chk("R7 fallback held", fallback, 1);
        clear_pulse();

        // Feedback loss in automatic mode.
        run[2] = 1'b0;
        wait_n(70);
        chk("R3 dual flags", bad0 & bad1, 1);
        chk("R7 fb loss fallback", fallback, 1);
        run[2] = 1'b1;
        wait_n(20);
        clear_pulse();

        // Override mode.
        man = 1'b1; pri = 1'b1;
        run[1] = 1'b0;
        wait_n(50);
        chk("R8 flag latches in override", bad1, 1);
        chk("R8 sel follows", sel, 1);
        pri = 1'b0; wait_n(1);
        chk("R8 sel follows change", sel, 0);
        chk("R8 no fallback", fallback, 0);
        run[1] = 1'b1;
        wait_n(10);
        clear_pulse();

        // Long feedback loss: fallback waits for activity.
        run[2] = 1'b0;
        cnt = 0;
        while (!fallback && cnt < 200) begin wait_n(1); cnt++; end
        chk("R9 fallback raised", fallback, 1);
        chk("R3 override dual flags", bad0 & bad1, 1);
        wait_n(300);
        chk("R9 held until activity", fallback, 1);
        run[2] = 1'b1;
        wait_n(30);
        chk("R9 released on activity", fallback, 0);
        clear_pulse();

        // Short feedback loss: exact minimum hold.
        run[2] = 1'b0;
        cnt = 0;
        while (!fallback && cnt < 200) begin wait_n(1); cnt++; end
        run[2] = 1'b1;
        cnt = 0;
        while (fallback && cnt < 1000) begin cnt++; wait_n(1); end
        chk("R9 min hold lower", (cnt >= HOLD) ? 1 : 0, 1);
        chk("R9 min hold upper", (cnt <= HOLD + 2) ? 1 : 0, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule